// File: doc/BRIEF.md
# Packetized Memory Command Receiver

This block sits at the device end of a memory channel. Commands reach it as packets on a narrow control bus that is separate from the data lines. It samples an 8-bit control bus on both edges of the clock, so one 64-bit packet arrives in eight beats over four clock periods. A start flag marks the first beat. The receiver assembles the packet and compares the packet's device field with the device's own identifier. It drops packets meant for other devices. It places accepted commands into one of eight transaction slots.

Packets keep arriving while earlier transactions are still in progress. Decoded command records go to a downstream core model in arrival order through a valid/ready handshake. Each record carries the index of the slot it holds. The core model reports that a transaction is finished by pulsing a completion with that slot index, and the slot is released one cycle later. If a matching packet arrives while all slots are busy, the packet is discarded and a sticky overflow flag is set.

Top module: `pktcmd_rx`

## Requirements
- R1: Synchronous active-low reset clears the framer, every slot and the overflow flag. After reset, `cmd_vld` is 0, `slot_busy` is 0 and `ovf_flag` is 0.
- R2: Within a clock period, the byte sampled at the rising edge comes before the byte sampled at the falling edge. The beat marked by `ctl_sop` becomes packet bits [63:56], and each later beat fills the next lower byte. The fields are: device [63:58], opcode [57:54], bank [53:50], address [49:30]. Bits [29:0] are reserved and ignored.
- R3: A packet whose device field differs from `dev_id` has no effect: no record appears and `slot_busy` does not change.
- R4: An accepted packet takes the lowest-numbered free slot. Records leave in arrival order. A record is held unchanged while `cmd_rdy` is low.
- R5: Packets sent back to back, with no idle beat between them, are all accepted.
- R6: A matching packet that arrives while all eight slots are busy is dropped, and `ovf_flag` is set. The flag stays set until reset.
- R7: A completion for a slot whose record has already been handed off clears that slot's `slot_busy` bit at the next clock edge. A completion for an idle slot, or for a slot whose record has not yet been handed off, is ignored.
- R8: When a completion and a packet accept decision fall in the same cycle, the slot being freed is not yet available. With all slots busy, the packet is dropped and the slot is still released.
- R9: A start flag seen in the middle of a packet restarts framing. The partial packet produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the control bus is sampled on both edges |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_id | input | 6 | This device's identifier |
| ctl_bus | input | 8 | Control bus byte |
| ctl_sop | input | 1 | Marks the rising-edge beat that starts a packet |
| cmd_vld | output | 1 | Command record available |
| cmd_rdy | input | 1 | Downstream accepts the record |
| cmd_slot | output | 3 | Slot index of the record |
| cmd_op | output | 4 | Opcode |
| cmd_bank | output | 4 | Bank |
| cmd_addr | output | 20 | Row/column address |
| cmp_vld | input | 1 | Completion pulse |
| cmp_slot | input | 3 | Slot index being completed |
| slot_busy | output | 8 | One bit per occupied slot |
| ovf_flag | output | 1 | Sticky dropped-packet flag |

## Verification
The case that needs care is a completion that lands in the same cycle as the accept decision for a matching packet while every slot is busy. The bench times the completion pulse onto the clock edge two edges after the last packet beat, which is the edge where the tracker decides. The result is judged from the ports. No new record appears. The completed slot's busy bit drops at that edge. A packet sent afterwards then lands in exactly the freed slot.

// File: rtl/pktcmd_pkg.sv
// Shared constants and the command record for the packet command receiver.
// Assumes the slot count is a power of two so that slot pointers wrap naturally.
package pktcmd_pkg;
    localparam int BUS_W    = 8;
    localparam int BEATS    = 8;
    localparam int PKT_W    = BUS_W * BEATS;
    localparam int ID_W     = 6;
    localparam int OP_W     = 4;
    localparam int BANK_W   = 4;
    localparam int ADDR_W   = 20;
    localparam int HDR_W    = ID_W + OP_W + BANK_W + ADDR_W;
    localparam int SLOTS    = 8;
    localparam int SLOT_W   = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [OP_W-1:0]   op;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } cmd_rec_t;
endpackage

// File: rtl/pktcmd_ddr_capture.sv
// Double-edge sampler: registers the control bus on the rising edge (with the
// start flag) and on the falling edge, and presents both as one pair word.
// Assumes the rising-edge beat precedes the falling-edge beat in a period.
module pktcmd_ddr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus,
    input  logic         sop,
    output logic [2*W-1:0] pair,
    output logic         pair_sop
);
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic         sop_q;

    // Rising-edge beat and its start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            sop_q  <= 1'b0;
        end else begin
            rise_q <= bus;
            sop_q  <= sop;
        end
    end

    // Falling-edge beat.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= bus;
    end

    assign pair     = {rise_q, fall_q};
    assign pair_sop = sop_q;
endmodule

// File: rtl/pktcmd_framer.sv
// Packet framer: shifts one beat pair per clock into a packet register and
// pulses pkt_vld once the last pair of a packet that began with a start flag
// has arrived. A start flag mid-packet restarts the count.
// Assumes PKT_W is a multiple of PAIR_W and OUT_W <= PKT_W.
module pktcmd_framer #(
    parameter int PAIR_W = 16,
    parameter int PKT_W  = 64,
    parameter int OUT_W  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] pair,
    input  logic              pair_sop,
    output logic              pkt_vld,
    output logic [OUT_W-1:0]  pkt_hdr
);
    localparam int PAIRS = PKT_W / PAIR_W;
    localparam int CNT_W = (PAIRS > 2) ? $clog2(PAIRS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);

    logic [PKT_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             active;

    // Shift pairs in and track the position inside the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            active  <= 1'b0;
            pkt_vld <= 1'b0;
        end else begin
            pkt_vld <= 1'b0;
            shreg   <= {shreg[PKT_W-PAIR_W-1:0], pair};
            if (pair_sop) begin
                active <= 1'b1;
                cnt    <= CNT_W'(1);
            end else if (active) begin
                if (cnt == LAST) begin
                    active  <= 1'b0;
                    cnt     <= '0;
                    pkt_vld <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign pkt_hdr = shreg[PKT_W-1 -: OUT_W];
endmodule

// File: rtl/pktcmd_order_fifo.sv
// Arrival-order queue of command records between the slot tracker and the
// downstream core. Assumes the caller never pushes when it is full.
module pktcmd_order_fifo
    import pktcmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  cmd_rec_t push_rec,
    input  logic     pop,
    output logic     head_vld,
    output cmd_rec_t head_rec
);
    localparam int PTR_W = $clog2(DEPTH);

    cmd_rec_t           mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W:0]     count;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    // Record storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_rec;
    end

    assign head_vld = (count != '0);
    assign head_rec = mem[rd_ptr];
endmodule

// File: rtl/pktcmd_slot_tracker.sv
// Transaction slot manager: allocates the lowest free slot to each accepted
// command, drops commands when full (sticky overflow), marks slots issued when
// their record leaves, and frees issued slots on completion at the next edge.
module pktcmd_slot_tracker
    import pktcmd_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [OP_W-1:0]   in_op,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              out_rdy,
    output logic              out_vld,
    output cmd_rec_t          out_rec,
    input  logic              done_vld,
    input  logic [SLOT_W-1:0] done_slot,
    output logic [NSLOT-1:0]  busy,
    output logic              ovf
);
    logic [NSLOT-1:0]  issued;
    logic [SLOT_W-1:0] free_idx;
    logic              any_free;
    logic              accept;
    logic              drop;
    logic              pop;
    logic              done_ok;
    cmd_rec_t          new_rec;

    // Lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_idx = SLOT_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign accept  = in_vld & any_free;
    assign drop    = in_vld & ~any_free;
    assign pop     = out_vld & out_rdy;
    assign done_ok = done_vld & busy[done_slot] & issued[done_slot];
    assign new_rec = '{slot: free_idx, op: in_op, bank: in_bank, addr: in_addr};

    // Slot occupancy, issue marks and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= '0;
            issued <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) busy[free_idx] <= 1'b1;
            if (pop)    issued[out_rec.slot] <= 1'b1;
            if (done_ok) begin
                busy[done_slot]   <= 1'b0;
                issued[done_slot] <= 1'b0;
            end
            if (drop) ovf <= 1'b1;
        end
    end

    pktcmd_order_fifo #(.DEPTH(NSLOT)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_rec (new_rec),
        .pop      (pop),
        .head_vld (out_vld),
        .head_rec (out_rec)
    );
endmodule

// File: rtl/pktcmd_rx.sv
// Top of the packet command receiver: double-edge capture, framing, device
// address match and slot tracking. Assumes the field layout in pktcmd_pkg.
module pktcmd_rx
    import pktcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [BUS_W-1:0]  ctl_bus,
    input  logic              ctl_sop,
    output logic              cmd_vld,
    input  logic              cmd_rdy,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [OP_W-1:0]   cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmp_vld,
    input  logic [SLOT_W-1:0] cmp_slot,
    output logic [SLOTS-1:0]  slot_busy,
    output logic              ovf_flag
);
    logic [2*BUS_W-1:0] pair;
    logic               pair_sop;
    logic               pkt_vld;
    logic [HDR_W-1:0]   hdr;
    logic               hit;
    cmd_rec_t           rec;

    pktcmd_ddr_capture #(.W(BUS_W)) i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus      (ctl_bus),
        .sop      (ctl_sop),
        .pair     (pair),
        .pair_sop (pair_sop)
    );

    pktcmd_framer #(.PAIR_W(2*BUS_W), .PKT_W(PKT_W), .OUT_W(HDR_W)) i_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair     (pair),
        .pair_sop (pair_sop),
        .pkt_vld  (pkt_vld),
        .pkt_hdr  (hdr)
    );

    // Device address compare on the header's top field.
    assign hit = pkt_vld & (hdr[HDR_W-1 -: ID_W] == dev_id);

    pktcmd_slot_tracker #(.NSLOT(SLOTS)) i_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (hit),
        .in_op     (hdr[HDR_W-ID_W-1 -: OP_W]),
        .in_bank   (hdr[HDR_W-ID_W-OP_W-1 -: BANK_W]),
        .in_addr   (hdr[ADDR_W-1:0]),
        .out_rdy   (cmd_rdy),
        .out_vld   (cmd_vld),
        .out_rec   (rec),
        .done_vld  (cmp_vld),
        .done_slot (cmp_slot),
        .busy      (slot_busy),
        .ovf       (ovf_flag)
    );

    assign cmd_slot = rec.slot;
    assign cmd_op   = rec.op;
    assign cmd_bank = rec.bank;
    assign cmd_addr = rec.addr;
endmodule

// File: rtl/pktcmd_rx_checker.sv
// Port-level protocol checks for pktcmd_rx, attached with bind below.
module pktcmd_rx_checker
    import pktcmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_vld,
    input logic              cmd_rdy,
    input logic [SLOT_W-1:0] cmd_slot,
    input logic [OP_W-1:0]   cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmp_vld,
    input logic [SLOT_W-1:0] cmp_slot,
    input logic [SLOTS-1:0]  slot_busy,
    input logic              ovf_flag
);
    // R1: state is clean in the first cycle after reset.
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (slot_busy == '0 && !ovf_flag && !cmd_vld));

    // R6: overflow flag never clears outside reset.
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_flag) |-> ovf_flag);

    // R4: a stalled record holds its contents.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !cmd_rdy) |=> (cmd_vld && $stable({cmd_slot, cmd_op, cmd_bank, cmd_addr})));

    // R4: at most one slot becomes busy per cycle.
    a_r4_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(slot_busy & ~$past(slot_busy)) <= 1));

    // R4: a presented record always refers to an occupied slot.
    a_r4_rec_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> slot_busy[cmd_slot]);

    // R7: a slot frees only after a completion naming it.
    a_r7_free_by_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |($past(slot_busy) & ~slot_busy)) |->
            ($past(cmp_vld) && !slot_busy[$past(cmp_slot)]));
endmodule

bind pktcmd_rx pktcmd_rx_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld   (cmd_vld),
    .cmd_rdy   (cmd_rdy),
    .cmd_slot  (cmd_slot),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .cmp_vld   (cmp_vld),
    .cmp_slot  (cmp_slot),
    .slot_busy (slot_busy),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_pktcmd_rx.sv
// Directed bench for pktcmd_rx: one task per scenario, each checking itself.
module test_pktcmd_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  dev_id = 6'h15;
    logic [7:0]  ctl_bus = '0;
    logic        ctl_sop = 1'b0;
    logic        cmd_vld;
    logic        cmd_rdy = 1'b0;
    logic [2:0]  cmd_slot;
    logic [3:0]  cmd_op;
    logic [3:0]  cmd_bank;
    logic [19:0] cmd_addr;
    logic        cmp_vld = 1'b0;
    logic [2:0]  cmp_slot = '0;
    logic [7:0]  slot_busy;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pktcmd_rx i_pktcmd_rx (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .ctl_bus(ctl_bus),
        .ctl_sop(ctl_sop), .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy),
        .cmd_slot(cmd_slot), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmp_vld(cmp_vld), .cmp_slot(cmp_slot),
        .slot_busy(slot_busy), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [5:0] id, input logic [3:0] op,
                                       input logic [3:0] bank, input logic [19:0] addr);
        return {id, op, bank, addr, 30'h2A5C_3E1F};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cmd_rdy = 1'b0; cmp_vld = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send the first n beat pairs of a packet: rising beat then falling beat.
    task automatic send_pairs(input logic [63:0] p, input int n);
        for (int b = 0; b < n; b++) begin
            @(negedge clk); #2;
            ctl_bus = p[63-16*b -: 8]; ctl_sop = (b == 0);
            @(posedge clk); #2;
            ctl_bus = p[55-16*b -: 8]; ctl_sop = 1'b0;
        end
    endtask

    task automatic send_pkt(input logic [63:0] p);
        send_pairs(p, 4);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Check the head record, then hand it off.
    task automatic pop_expect(input string req, input logic [2:0] slot, input logic [3:0] op);
        check(req, {63'b0, cmd_vld}, 64'd1);
        check(req, {61'b0, cmd_slot}, {61'b0, slot});
        check(req, {60'b0, cmd_op}, {60'b0, op});
        cmd_rdy = 1'b1;
        @(negedge clk);
        cmd_rdy = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 cmd_vld", {63'b0, cmd_vld}, 64'd0);
        check("R1 slot_busy", {56'b0, slot_busy}, 64'd0);
        check("R1 ovf_flag", {63'b0, ovf_flag}, 64'd0);
    endtask

    task automatic t_decode_and_hold();
        send_pkt(mk(6'h15, 4'h5, 4'hA, 20'hABCDE));
        settle();
        check("R2 op", {60'b0, cmd_op}, 64'h5);
        check("R2 bank", {60'b0, cmd_bank}, 64'hA);
        check("R2 addr", {44'b0, cmd_addr}, 64'hABCDE);
        check("R4 slot", {61'b0, cmd_slot}, 64'd0);
        check("R4 busy", {56'b0, slot_busy}, 64'h01);
        repeat (2) @(negedge clk);
        check("R4 hold addr", {44'b0, cmd_addr}, 64'hABCDE);
        pop_expect("R4 pop", 3'd0, 4'h5);
        check("R4 emptied", {63'b0, cmd_vld}, 64'd0);
    endtask

    task automatic t_foreign();
        send_pkt(mk(6'h2A, 4'h3, 4'h1, 20'h12345));
        settle();
        check("R3 no record", {63'b0, cmd_vld}, 64'd0);
        check("R3 busy unchanged", {56'b0, slot_busy}, 64'h01);
    endtask

    task automatic t_complete();
        @(negedge clk);
        cmp_vld = 1'b1; cmp_slot = 3'd5;
        @(negedge clk);
        cmp_vld = 1'b0;
        check("R7 idle slot completion ignored", {56'b0, slot_busy}, 64'h01);
        cmp_vld = 1'b1; cmp_slot = 3'd0;
        check("R7 busy before edge", {56'b0, slot_busy}, 64'h01);
        @(negedge clk);
        cmp_vld = 1'b0;
        check("R7 freed after edge", {56'b0, slot_busy}, 64'h00);
    endtask

    task automatic t_back_to_back();
        do_reset();
        send_pkt(mk(6'h15, 4'h7, 4'h2, 20'h00011));
        send_pkt(mk(6'h15, 4'h9, 4'h3, 20'h00022));
        settle();
        check("R5 both busy", {56'b0, slot_busy}, 64'h03);
        pop_expect("R5 first", 3'd0, 4'h7);
        pop_expect("R5 second", 3'd1, 4'h9);
        check("R5 drained", {63'b0, cmd_vld}, 64'd0);
    endtask

    task automatic t_fill_overflow_collision();
        do_reset();
        for (int k = 0; k < 8; k++) send_pkt(mk(6'h15, 4'(k), 4'h0, 20'(k)));
        send_pkt(mk(6'h15, 4'hE, 4'h0, 20'h0));
        settle();
        check("R6 all busy", {56'b0, slot_busy}, 64'hFF);
        check("R6 overflow set", {63'b0, ovf_flag}, 64'd1);
        @(negedge clk);
        cmp_vld = 1'b1; cmp_slot = 3'd2;
        @(negedge clk);
        cmp_vld = 1'b0;
        check("R7 unissued completion ignored", {56'b0, slot_busy}, 64'hFF);
        for (int k = 0; k < 8; k++) pop_expect("R4 order", 3'(k), 4'(k));
        check("R6 dropped packet absent", {63'b0, cmd_vld}, 64'd0);
        // R8: completion on the same edge as the accept decision.
        send_pkt(mk(6'h15, 4'hC, 4'h0, 20'h0));
        @(posedge clk); #2;
        cmp_vld = 1'b1; cmp_slot = 3'd3;
        @(posedge clk); #2;
        cmp_vld = 1'b0;
        settle();
        check("R8 packet dropped", {63'b0, cmd_vld}, 64'd0);
        check("R8 slot released", {56'b0, slot_busy}, 64'hF7);
        check("R6 still set", {63'b0, ovf_flag}, 64'd1);
        send_pkt(mk(6'h15, 4'hD, 4'h0, 20'h0));
        settle();
        check("R4 lowest free reused", {56'b0, slot_busy}, 64'hFF);
        pop_expect("R8 new in freed slot", 3'd3, 4'hD);
    endtask

    task automatic t_restart();
        do_reset();
        send_pairs(mk(6'h15, 4'h1, 4'h0, 20'h0), 2);
        send_pkt(mk(6'h15, 4'h2, 4'h4, 20'h55555));
        settle();
        check("R9 one busy", {56'b0, slot_busy}, 64'h01);
        check("R9 addr", {44'b0, cmd_addr}, 64'h55555);
        pop_expect("R9 restarted packet", 3'd0, 4'h2);
        check("R9 no partial record", {63'b0, cmd_vld}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_decode_and_hold();
        t_foreign();
        t_complete();
        t_back_to_back();
        t_fill_overflow_collision();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule